// File: doc/BRIEF.md
# Stepped Two-Way Intersection Lamp Sequencer

This block runs the lamps of a crossing with two approaches, north/south and east/west. A 4-bit step counter moves one position on each rising clock edge while its enable is high. It runs from 0 to 15 and then starts again at 0. The counter value goes through a fixed combinational decode to a red, yellow or green aspect for each approach. Each phase of green and then yellow is preceded by one step in which both approaches show red.

The clock may be a free-running clock or a clean, debounced step pulse. An active-high asynchronous reset sets the counter to step 0 at once, and stepping resumes after reset is released. Every lamp is driven twice. One output is high when the lamp is lit. The other is its complement, low when the lamp is lit, for display segments that light on a low level.

Top module: `traffic_seq_ctrl`

## Requirements
- R1: While `rst` is high the counter is 0, with no wait for a clock edge. The outputs then show red on both approaches. After `rst` falls, the first enabled rising edge moves the counter to step 1.
- R2: On each rising edge of `clk` with `step_en` = 1, the step goes up by exactly one.
- R3: On a rising edge with `step_en` = 0, the step and all lamp outputs stay unchanged.
- R4: From step 15, an enabled edge moves the counter to step 0.
- R5: Steps 0 and 8 light red on both approaches.
- R6: Steps 1 to 5 light north/south green. Steps 6 and 7 light north/south yellow. East/west shows red in steps 1 to 7.
- R7: Steps 9 to 13 light east/west green. Steps 14 and 15 light east/west yellow. North/south shows red in steps 9 to 15.
- R8: Each `*_n` output is the bitwise complement of the active-high output of the same name.
- R9: Each approach has exactly one of its three active-high lamps lit at every step.
- R10: Green or yellow is never lit on both approaches in the same step.
- R11: The lamp outputs change only after a rising clock edge or a reset. They stay constant between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; rising edge advances |
| rst | input | 1 | Asynchronous active-high clear to step 0 |
| step_en | input | 1 | Counter advances only while high |
| ns_red | output | 1 | North/south red, high = lit |
| ns_yel | output | 1 | North/south yellow, high = lit |
| ns_grn | output | 1 | North/south green, high = lit |
| ew_red | output | 1 | East/west red, high = lit |
| ew_yel | output | 1 | East/west yellow, high = lit |
| ew_grn | output | 1 | East/west green, high = lit |
| ns_red_n | output | 1 | North/south red, low = lit |
| ns_yel_n | output | 1 | North/south yellow, low = lit |
| ns_grn_n | output | 1 | North/south green, low = lit |
| ew_red_n | output | 1 | East/west red, low = lit |
| ew_yel_n | output | 1 | East/west yellow, low = lit |
| ew_grn_n | output | 1 | East/west green, low = lit |

## Verification
Three stimulus patterns are used:
- Continuous enable over more than two full laps. This walks every step, including the wrap from 15 to 0, and it separates a correct schedule from one with a shifted boundary.
- An enable that toggles or stays low for several cycles. This exposes a counter that ignores the enable or skips a step.
- A reset raised between clock edges. This shows whether the clear acts at once or waits for the next edge.

Outputs are compared with a behavioural count model at two points inside each cycle. The second sample catches any change between edges.

// File: rtl/traffic_pkg.sv
package traffic_pkg;

    localparam int STEP_W = 4;

    // schedule boundaries; the decode depends on this order
    localparam int NS_GO_FIRST   = 1;
    localparam int NS_WARN_FIRST = 6;
    localparam int MID_CLEAR     = 8;
    localparam int EW_GO_FIRST   = 9;
    localparam int EW_WARN_FIRST = 14;

    typedef enum logic [1:0] {
        ASP_STOP = 2'd0,
        ASP_WARN = 2'd1,
        ASP_GO   = 2'd2
    } aspect_e;

    typedef struct packed {
        aspect_e ns;
        aspect_e ew;
    } phase_t;

    function automatic phase_t step_to_phase(input logic [STEP_W-1:0] s);
        phase_t p;
        int unsigned v;
        v    = int'(s);
        p.ns = ASP_STOP;
        p.ew = ASP_STOP;
        if (v >= NS_GO_FIRST && v < NS_WARN_FIRST)
            p.ns = ASP_GO;
        else if (v >= NS_WARN_FIRST && v < MID_CLEAR)
            p.ns = ASP_WARN;
        else if (v >= EW_GO_FIRST && v < EW_WARN_FIRST)
            p.ew = ASP_GO;
        else if (v >= EW_WARN_FIRST)
            p.ew = ASP_WARN;
        return p;
    endfunction

endpackage

// File: rtl/step_counter.sv
module step_counter #(
    parameter int W = traffic_pkg::STEP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or posedge rst) begin
        if (rst)
            cnt <= '0;
        else if (en)
            cnt <= cnt + W'(1);
    end

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt == W'($past(cnt) + W'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == TOP) |=> cnt == '0);

endmodule

// File: rtl/phase_decode.sv
module phase_decode
    import traffic_pkg::*;
#(
    parameter int W = STEP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] step,
    output phase_t       phase
);
    always_comb phase = step_to_phase(step);

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (step == W'(0) || step == W'(MID_CLEAR)) |->
        (phase.ns == ASP_STOP && phase.ew == ASP_STOP));

    p_ns_side_r6: assert property (@(posedge clk) disable iff (rst)
        (step >= W'(NS_GO_FIRST) && step < W'(MID_CLEAR)) |->
        (phase.ew == ASP_STOP && phase.ns != ASP_STOP));

    p_ew_side_r7: assert property (@(posedge clk) disable iff (rst)
        (step >= W'(EW_GO_FIRST)) |->
        (phase.ns == ASP_STOP && phase.ew != ASP_STOP));

endmodule

// File: rtl/lamp_driver.sv
module lamp_driver
    import traffic_pkg::*;
(
    input  aspect_e    asp,
    output logic [2:0] lit,
    output logic [2:0] lit_n
);
    // lit[0]=red lit[1]=yellow lit[2]=green
    always_comb begin
        lit = 3'b000;
        unique case (asp)
            ASP_STOP: lit[0] = 1'b1;
            ASP_WARN: lit[1] = 1'b1;
            ASP_GO:   lit[2] = 1'b1;
            default:  lit[0] = 1'b1;
        endcase
        lit_n = ~lit;
    end
endmodule

// File: rtl/traffic_seq_ctrl.sv
module traffic_seq_ctrl
    import traffic_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    output logic ns_red,
    output logic ns_yel,
    output logic ns_grn,
    output logic ew_red,
    output logic ew_yel,
    output logic ew_grn,
    output logic ns_red_n,
    output logic ns_yel_n,
    output logic ns_grn_n,
    output logic ew_red_n,
    output logic ew_yel_n,
    output logic ew_grn_n
);
    localparam int N_DIR = 2;

    logic [STEP_W-1:0] step;
    phase_t            phase;
    aspect_e           asp   [N_DIR];
    logic [2:0]        lit   [N_DIR];
    logic [2:0]        lit_n [N_DIR];

    step_counter #(.W(STEP_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .en  (step_en),
        .cnt (step)
    );

    phase_decode #(.W(STEP_W)) u_dec (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .phase (phase)
    );

    assign asp[0] = phase.ns;
    assign asp[1] = phase.ew;

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        lamp_driver u_drv (
            .asp   (asp[d]),
            .lit   (lit[d]),
            .lit_n (lit_n[d])
        );
    end

    assign {ns_grn, ns_yel, ns_red}       = lit[0];
    assign {ew_grn, ew_yel, ew_red}       = lit[1];
    assign {ns_grn_n, ns_yel_n, ns_red_n} = lit_n[0];
    assign {ew_grn_n, ew_yel_n, ew_red_n} = lit_n[1];

    p_one_lamp_r9: assert property (@(posedge clk) disable iff (rst)
        $countones({ns_red, ns_yel, ns_grn}) == 1 &&
        $countones({ew_red, ew_yel, ew_grn}) == 1);

    p_no_conflict_r10: assert property (@(posedge clk) disable iff (rst)
        !((ns_grn || ns_yel) && (ew_grn || ew_yel)));

    p_reset_red_r1: assert property (@(posedge clk)
        rst |-> (ns_red && ew_red));

endmodule

// File: tb/traffic_seq_ctrl_tb_top.sv
module traffic_seq_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic step_en = 1'b0;
    logic ns_red, ns_yel, ns_grn, ew_red, ew_yel, ew_grn;
    logic ns_red_n, ns_yel_n, ns_grn_n, ew_red_n, ew_yel_n, ew_grn_n;

    int n_chk = 0;
    int n_bad = 0;
    int model = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    traffic_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .step_en(step_en),
        .ns_red(ns_red), .ns_yel(ns_yel), .ns_grn(ns_grn),
        .ew_red(ew_red), .ew_yel(ew_yel), .ew_grn(ew_grn),
        .ns_red_n(ns_red_n), .ns_yel_n(ns_yel_n), .ns_grn_n(ns_grn_n),
        .ew_red_n(ew_red_n), .ew_yel_n(ew_yel_n), .ew_grn_n(ew_grn_n)
    );

    // expected lamps {grn,yel,red} per approach from the step number
    function automatic logic [2:0] exp_ns(int s);
        if (s >= 1 && s <= 5) return 3'b100;
        if (s == 6 || s == 7) return 3'b010;
        return 3'b001;
    endfunction

    function automatic logic [2:0] exp_ew(int s);
        if (s >= 9 && s <= 13) return 3'b100;
        if (s >= 14) return 3'b010;
        return 3'b001;
    endfunction

    function automatic string sched_tag(int s);
        if (s == 0 || s == 8) return "R5";
        if (s <= 7) return "R6";
        return "R7";
    endfunction

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s step=%0d actual=%b expected=%b", tag, model, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        logic [5:0] act, actn;
        act  = {ns_grn, ns_yel, ns_red, ew_grn, ew_yel, ew_red};
        actn = {ns_grn_n, ns_yel_n, ns_red_n, ew_grn_n, ew_yel_n, ew_red_n};
        chk({ctx, "/", sched_tag(model)}, act, {exp_ns(model), exp_ew(model)});
        chk("R8", actn, ~act);
        chk("R9", {4'b0, ($countones(act[5:3]) == 1), ($countones(act[2:0]) == 1)}, 6'b000011);
        chk("R10", {5'b0, ((act[5] | act[4]) & (act[2] | act[1]))}, 6'b0);
    endtask

    // one clock: drive enable at negedge, model the edge, check at next negedge and again later
    task automatic cycle(logic en);
        logic [5:0] first;
        string tag;
        tag = en ? ((model == 15) ? "R4" : "R2") : "R3";
        step_en = en;
        @(posedge clk);
        if (en) model = (model + 1) % 16;
        @(negedge clk);
        check_all(tag);
        first = {ns_grn, ns_yel, ns_red, ew_grn, ew_yel, ew_red};
        #5;
        chk("R11", {ns_grn, ns_yel, ns_red, ew_grn, ew_yel, ew_red}, first);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        model = 0;
        check_all("R1");
        rst = 1'b0;
        // continuous run over two laps plus
        for (int i = 0; i < 40; i++) cycle(1'b1);
        // holds
        for (int i = 0; i < 5; i++) cycle(1'b0);
        // alternating enable
        for (int i = 0; i < 30; i++) cycle(i[0]);
        // bursts
        for (int i = 0; i < 24; i++) cycle((i % 5) != 0);
        // asynchronous reset mid-cycle
        while (model == 0) cycle(1'b1);
        #3;
        rst = 1'b1;
        #2;
        model = 0;
        check_all("R1");
        step_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        cycle(1'b1);
        chk("R1", {5'b0, ns_grn}, 6'b000001);
        for (int i = 0; i < 20; i++) cycle(1'b1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule